// File: doc/BRIEF.md
# Four-Channel Photon Coincidence Counter

This block counts single-photon detector events on four channels (A, B, C, D) and every coincidence among them. Each detector line is asynchronous to the block clock. It is sampled through a two-stage synchroniser, and a rising edge is detected after that. Each detected edge opens a per-channel window. The window stays high for a run-time programmable number of clock cycles, from 1 to 255. A group of two or more channels is coincident when all of its windows are high in the same cycle. Overlaps that pass through a third channel do not link the two outer channels.

The block holds sixteen saturating counters, each selected by a 4-bit subset mask (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D):
- the four one-hot masks count detector edges;
- the eleven masks with two or more bits set count overlap episodes;
- mask zero counts elapsed clock cycles, which gives a time base for rates.

One mask picks a counter for a 16-bit display output. A second, independent mask reads any full counter. A mode input can replace the detector lines with an internal pseudo-random pulse source for bring-up without detectors.

Each window unit runs a two-state machine:
- States: `W_IDLE` and `W_OPEN`.
- Transitions: *open-on-edge* (`W_IDLE`→`W_OPEN`), *reload-on-edge* (`W_OPEN`→`W_OPEN`, countdown restarts), *count-down* (`W_OPEN`→`W_OPEN`) and *close-at-zero* (`W_OPEN`→`W_IDLE`).

Each coincidence counter runs an episode machine:
- States: `E_WAIT` and `E_HELD`.
- Transitions: *arm-and-count* (`E_WAIT`→`E_HELD`, taken in the first cycle all member windows are high, and this is the counting cycle) and *release* (`E_HELD`→`E_WAIT`, taken when any member window drops).

Top module: `coinc_counter4`

## Requirements
- R1: Each detector line passes a two-flop synchroniser. Each synchronised rising edge increments that channel's singles counter (mask 0001=A, 0010=B, 0100=C, 1000=D) by exactly one, including edges that arrive while the window is already open.
- R2: A detected edge opens the channel window for exactly `win_len` cycles. A value of 0 is treated as 1. Two channels firing d cycles apart overlap only when d < `win_len`.
- R3: An edge that arrives while its channel's window is open restarts the full window length from that edge.
- R4: A counter whose mask has two or more bits set increments once per overlap episode. It counts in the first cycle in which all member windows are high, and it does not count again until at least one member window has dropped.
- R5: Overlap is not transitive. If A overlaps B and B overlaps C but A and C never overlap, then AB and BC count while AC and ABC stay unchanged.
- R6: `disp_val` shows the low 16 bits of the counter selected by the mask `disp_sel`, zero-extended when counters are narrower than 16 bits.
- R7: `rd_val` returns the full counter selected by the mask `rd_sel`, using the same mask encoding.
- R8: Mask 0000 is an elapsed-cycle counter that increments on every clock edge after reset or clear.
- R9: Every counter saturates at its all-ones value and holds there.
- R10: A synchronous `clr` zeroes every counter at the clock edge where it is sampled high, and it takes priority over an increment in that cycle.
- R11: With `use_test` high, the detector lines are ignored and an internal pseudo-random pulse source drives all four channels. With it low and the lines idle, no counter except elapsed moves.
- R12: After reset all windows are closed and every event counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| det_in | input | 4 | Raw detector lines, bit 0 = A .. bit 3 = D |
| use_test | input | 1 | 1 selects the internal pulse source |
| win_len | input | WIN_W (8) | Window length in cycles (0 acts as 1) |
| disp_sel | input | 4 | Subset mask for the display |
| disp_val | output | DISP_W (16) | Low bits of the selected counter |
| rd_sel | input | 4 | Subset mask for the readout |
| rd_val | output | CNT_W (32) | Full value of the selected counter |

## Verification
A window state machine stuck open or closing one cycle early does not show on any port directly. It shows as a coincidence count that is one too high or one too low for the overlap patterns driven at exactly d = `win_len` − 1 and d = `win_len`, and the readout shows this a few cycles after the windows settle. An episode machine that fails to leave `E_HELD` stops its counter from advancing on the next overlap. One that never enters `E_HELD` counts every overlapping cycle, so a single episode reads several counts instead of one. A synchroniser or edge detector that is wrong in the same way shows as singles counts that do not match the number of pulses driven.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    localparam int NCH  = 4;
    localparam int NSUB = 1 << NCH;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_OPEN = 1'b1
    } win_st_t;

    typedef enum logic {
        E_WAIT = 1'b0,
        E_HELD = 1'b1
    } ep_st_t;

    function automatic int ones4(input logic [NCH-1:0] m);
        int n;
        n = 0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/det_window.sv
module det_window
    import coinc_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [WIN_W-1:0] len,
    output logic             rise,
    output logic             win
);

    logic s1, s2, s3;
    win_st_t st, st_nx;
    logic [WIN_W-1:0] rem, rem_nx, len_m1;

    // two-flop synchroniser plus edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise   = s2 & ~s3;
    assign len_m1 = (len == '0) ? '0 : len - 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= W_IDLE;
            rem <= '0;
        end else begin
            st  <= st_nx;
            rem <= rem_nx;
        end
    end

    // next state
    always_comb begin
        st_nx  = st;
        rem_nx = rem;
        unique case (st)
            W_IDLE: begin
                if (rise) begin
                    st_nx  = W_OPEN;
                    rem_nx = len_m1;
                end
            end
            W_OPEN: begin
                if (rise) begin
                    rem_nx = len_m1;
                end else if (rem == '0) begin
                    st_nx = W_IDLE;
                end else begin
                    rem_nx = rem - 1'b1;
                end
            end
            default: st_nx = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        win = (st == W_OPEN);
    end

endmodule

// File: rtl/test_pulser.sv
module test_pulser
    import coinc_pkg::*;
#(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [NCH-1:0] pulse
);

    localparam logic [15:0] TAPS = 16'hB400;

    logic [15:0] lfsr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= SEED;
        end else if (lfsr[0]) begin
            lfsr <= (lfsr >> 1) ^ TAPS;
        end else begin
            lfsr <= lfsr >> 1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse[c] <= 1'b0;
            else        pulse[c] <= &lfsr[4*c +: 4];
        end
    end

endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && (q != '1)) begin
            q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/coinc_bank.sv
module coinc_bank
    import coinc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic [NCH-1:0]              rise,
    input  logic [NCH-1:0]              win,
    output logic [NSUB-1:0][CNT_W-1:0]  cnt
);

    for (genvar m = 0; m < NSUB; m++) begin : g_sub
        localparam logic [NCH-1:0] MASK = NCH'(m);
        localparam int K = ones4(MASK);
        logic inc;

        if (K == 0) begin : g_time
            assign inc = 1'b1;
        end else if (K == 1) begin : g_single
            assign inc = |(rise & MASK);
        end else begin : g_coinc
            ep_st_t st, st_nx;
            logic   all_hi;

            assign all_hi = &(win | ~MASK);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st <= E_WAIT;
                else        st <= st_nx;
            end

            always_comb begin
                st_nx = st;
                unique case (st)
                    E_WAIT:  if (all_hi)  st_nx = E_HELD;
                    E_HELD:  if (!all_hi) st_nx = E_WAIT;
                    default: st_nx = E_WAIT;
                endcase
            end

            always_comb begin
                inc = (st == E_WAIT) && all_hi;
            end
        end

        sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc),
            .q     (cnt[m])
        );
    end

endmodule

// File: rtl/coinc_counter4.sv
module coinc_counter4
    import coinc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WIN_W  = 8,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [3:0]        det_in,
    input  logic              use_test,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [3:0]        disp_sel,
    output logic [DISP_W-1:0] disp_val,
    input  logic [3:0]        rd_sel,
    output logic [CNT_W-1:0]  rd_val
);

    logic [NCH-1:0]             tp;
    logic [NCH-1:0]             raw;
    logic [NCH-1:0]             rise;
    logic [NCH-1:0]             win;
    logic [NSUB-1:0][CNT_W-1:0] cnt;

    test_pulser u_tp (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (tp)
    );

    assign raw = use_test ? tp : det_in;

    for (genvar c = 0; c < NCH; c++) begin : g_win
        det_window #(.WIN_W(WIN_W)) u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw[c]),
            .len   (win_len),
            .rise  (rise[c]),
            .win   (win[c])
        );
    end

    coinc_bank #(.CNT_W(CNT_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .rise  (rise),
        .win   (win),
        .cnt   (cnt)
    );

    assign rd_val = cnt[rd_sel];

    if (CNT_W >= DISP_W) begin : g_disp_trunc
        assign disp_val = cnt[disp_sel][DISP_W-1:0];
    end else begin : g_disp_ext
        assign disp_val = {{(DISP_W-CNT_W){1'b0}}, cnt[disp_sel]};
    end

endmodule

// File: rtl/coinc_counter4_chk.sv
module coinc_counter4_chk
    import coinc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clr,
    input logic [NCH-1:0]             rise,
    input logic [NCH-1:0]             win,
    input logic [NSUB-1:0][CNT_W-1:0] cnt
);

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R2: an edge opens the window on the next cycle
        a_r2_opens: assert property (@(posedge clk) disable iff (!rst_n)
            rise[c] |=> win[c]);
    end

    // R8: elapsed counter advances every cycle until saturation
    a_r8_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(clr) && ($past(cnt[0]) != '1)) |->
            (cnt[0] == CNT_W'($past(cnt[0]) + 1'b1)));

    for (genvar m = 0; m < NSUB; m++) begin : g_cnt
        localparam logic [NCH-1:0] MASK = NCH'(m);

        // R10: clear zeroes the counter on the following sample
        a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && $past(clr)) |-> (cnt[m] == '0));

        // R9: a saturated counter holds
        a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && !$past(clr) && ($past(cnt[m]) == '1)) |-> (cnt[m] == '1));

        // R4: at most one step per cycle
        a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && !$past(clr)) |->
                ((cnt[m] == $past(cnt[m])) || (cnt[m] == CNT_W'($past(cnt[m]) + 1'b1))));

        if (ones4(MASK) >= 2) begin : g_co
            // R4: a coincidence step needs all member windows high the cycle before
            a_r4_cause: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && !$past(clr) && (cnt[m] != $past(cnt[m]))) |->
                    $past(&(win | ~MASK)));
        end
    end

endmodule

bind coinc_counter4 coinc_counter4_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .rise  (rise),
    .win   (win),
    .cnt   (cnt)
);

// File: tb/sim_coinc_counter4.sv
`timescale 1ns/1ps
module sim_coinc_counter4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [3:0]  det_in = 4'h0;
    logic        use_test = 1'b0;
    logic [7:0]  win_len = 8'd4;
    logic [3:0]  disp_sel = 4'h0;
    logic [15:0] disp_val;
    logic [3:0]  rd_sel = 4'h0;
    logic [31:0] rd_val;
    logic [15:0] disp_val1;
    logic [3:0]  rd_val1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coinc_counter4 u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .det_in(det_in),
        .use_test(use_test), .win_len(win_len), .disp_sel(disp_sel),
        .disp_val(disp_val), .rd_sel(rd_sel), .rd_val(rd_val)
    );

    // narrow instance for saturation
    coinc_counter4 #(.CNT_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .det_in(4'h0),
        .use_test(1'b0), .win_len(8'd1), .disp_sel(4'h0),
        .disp_val(disp_val1), .rd_sel(4'h0), .rd_val(rd_val1)
    );

    typedef struct {
        string       req;
        logic [3:0]  sel;
        logic [31:0] exp;
        bit          disp;
        bit          nz;
    } item_t;

    item_t sbq[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_cnt(input string req, input logic [3:0] sel, input logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp; it.disp = 1'b0; it.nz = 1'b0;
        sbq.push_back(it);
    endtask

    task automatic expect_disp(input string req, input logic [3:0] sel, input logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp; it.disp = 1'b1; it.nz = 1'b0;
        sbq.push_back(it);
    endtask

    task automatic expect_nz(input string req, input logic [3:0] sel);
        item_t it;
        it.req = req; it.sel = sel; it.exp = 32'd0; it.disp = 1'b0; it.nz = 1'b1;
        sbq.push_back(it);
    endtask

    // monitor: pops expected items and compares the design's outputs
    task automatic monitor();
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            @(negedge clk);
            if (it.disp) disp_sel = it.sel;
            else         rd_sel = it.sel;
            #1;
            act = it.disp ? {16'h0, disp_val} : rd_val;
            if (it.nz) begin
                checks++;
                if (act == 32'd0) begin
                    failures++;
                    $display("FAIL %s actual=%0d expected=nonzero", it.req, act);
                end
            end else begin
                check(it.req, act, it.exp);
            end
        end
    endtask

    task automatic step(input logic [3:0] v);
        @(negedge clk);
        det_in = v;
    endtask

    task automatic settle();
        repeat (20) step(4'h0);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state of every event counter
        for (int m = 1; m < 16; m++) expect_cnt("R12 reset", 4'(m), 32'd0);
        monitor();

        // R8: elapsed counter after a clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        repeat (37) @(negedge clk);
        rd_sel = 4'h0; #1;
        check("R8 elapsed", rd_val, 32'd37);

        // R2: window 4, B 3 cycles after A overlaps
        win_len = 8'd4;
        settle(); do_clear();
        step(4'h1); step(4'h0); step(4'h0); step(4'h2); settle();
        expect_cnt("R1 single A", 4'h1, 32'd1);
        expect_cnt("R1 single B", 4'h2, 32'd1);
        expect_cnt("R2 AB d=3", 4'h3, 32'd1);
        monitor();

        // R2: 4 cycles apart does not overlap
        do_clear();
        step(4'h1); step(4'h0); step(4'h0); step(4'h0); step(4'h2); settle();
        expect_cnt("R2 AB d=4", 4'h3, 32'd0);
        expect_cnt("R1 single B", 4'h2, 32'd1);
        monitor();

        // R3: retrigger extends A window
        do_clear();
        step(4'h1); step(4'h0); step(4'h0); step(4'h1);
        step(4'h0); step(4'h0); step(4'h2); settle();
        expect_cnt("R1 single A retrig", 4'h1, 32'd2);
        expect_cnt("R3 AB after retrigger", 4'h3, 32'd1);
        expect_disp("R6 display A", 4'h1, 32'd2);
        monitor();

        // R5: chain A-B-C
        do_clear();
        step(4'h1); step(4'h0); step(4'h0); step(4'h2);
        step(4'h0); step(4'h0); step(4'h4); settle();
        expect_cnt("R5 AB", 4'h3, 32'd1);
        expect_cnt("R5 BC", 4'h6, 32'd1);
        expect_cnt("R5 AC", 4'h5, 32'd0);
        expect_cnt("R5 ABC", 4'h7, 32'd0);
        monitor();

        // R4: one episode despite B retrigger, second episode after a gap
        win_len = 8'd6;
        do_clear();
        step(4'h1); step(4'h2); step(4'h0); step(4'h0); step(4'h2);
        step(4'h0); step(4'h0); step(4'h0); step(4'h0); step(4'h1);
        settle();
        expect_cnt("R4 AB episodes", 4'h3, 32'd2);
        expect_cnt("R1 single A", 4'h1, 32'd2);
        expect_cnt("R1 single B", 4'h2, 32'd2);
        monitor();

        // R2: zero length acts as one cycle
        win_len = 8'd0;
        do_clear();
        step(4'h3); step(4'h0); step(4'h1); step(4'h2); settle();
        expect_cnt("R2 len0 AB", 4'h3, 32'd1);
        expect_cnt("R2 len0 A", 4'h1, 32'd2);
        monitor();

        // R7 / R6: all four together, every subset counts once
        win_len = 8'd2;
        do_clear();
        step(4'hF); step(4'h0); settle();
        for (int m = 1; m < 16; m++) expect_cnt("R7 quad subset", 4'(m), 32'd1);
        expect_disp("R6 display ACD", 4'hD, 32'd1);
        monitor();

        // R10: clear zeroes all event counters
        do_clear();
        for (int m = 1; m < 16; m++) expect_cnt("R10 cleared", 4'(m), 32'd0);
        monitor();

        // R11: test source drives channels with lines idle
        use_test = 1'b1;
        repeat (2000) step(4'h0);
        for (int m = 1; m < 16; m = m << 1) expect_nz("R11 test source", 4'(m));
        monitor();
        use_test = 1'b0;
        settle(); do_clear();
        repeat (50) step(4'h0);
        for (int m = 1; m < 16; m++) expect_cnt("R11 idle lines", 4'(m), 32'd0);
        monitor();

        // R9: narrow instance saturates
        @(negedge clk); #1;
        check("R9 saturate rd", {28'h0, rd_val1}, 32'd15);
        check("R9 saturate disp", {16'h0, disp_val1}, 32'd15);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule